// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Unit

This unit resolves data hazards for a five-stage in-order integer pipeline. The stages, in order, are fetch, decode with register read, execute, memory access and write back. Every instruction passes through all five stages, even when a stage has nothing to do for it. Each cycle the unit looks at the source register numbers of the instruction in decode and of the instruction in execute. It also looks at the destination number, write flag and load flag of the producers in execute, memory and write back. From these it picks, for each execute operand, where the value comes from: the register file, the write-back result or the memory-stage result. This lets a dependent instruction use an ALU result before that result is written back.

A load cannot hand its data to the instruction right behind it in time. When the instruction in decode reads the register that a load in execute is about to fill, the unit raises `stall`. The surrounding pipeline then keeps its PC and its fetch/decode register unchanged and puts a bubble into execute, with all write controls cleared. That one bubble acts exactly like a no-op placed in the slot after the load. One cycle later the loaded value reaches the consumer through the write-back bypass. If the slot after a load does not use the load's result, no bubble is inserted.

The unit also holds the register file. Its two read ports serve the decode stage, and its write port is driven by write back. A write and a read of the same register in the same cycle return the new value. This covers a consumer three instructions behind its producer, so no bypass path is needed for that distance.

Top module: `hz_pipe_hazard`

## Requirements
- R1: An execute operand whose source matches a memory-stage producer that writes a register and is not a load gets select 2'b10, the memory-stage result.
- R2: An operand not served under R1 whose source matches a write-back producer that writes a register gets select 2'b01, the write-back value.
- R3: A match under R1 takes priority over a match under R2. An operand with neither match gets select 2'b00, the register file value. The value 2'b11 never appears.
- R4: `stall` is high when the execute-stage instruction is a load that writes a nonzero register, and that register equals either decode source.
- R5: `stall` is low in every other case, including when the instruction right after a load does not use the load's destination.
- R6: A read port whose address equals the write-back destination in a cycle with the write enabled returns the value being written in that same cycle.
- R7: Register 0 reads as zero, is never written, never selects a bypass and never causes a stall.
- R8: After reset, every register reads as zero, and with idle inputs both selects are 2'b00 and `stall` is low.
- R9: A program run through a pipeline built around the unit costs exactly one bubble per adjacent load-use pair. Its final register values equal those of a one-instruction-at-a-time execution.
- R10: A value written to a nonzero register is returned by later reads of that register until it is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_src1 | input | 5 | First source register of the decode-stage instruction |
| dec_src2 | input | 5 | Second source register of the decode-stage instruction |
| exe_src1 | input | 5 | First source register of the execute-stage instruction |
| exe_src2 | input | 5 | Second source register of the execute-stage instruction |
| exe_dst | input | 5 | Destination register of the execute-stage instruction |
| exe_wr | input | 1 | Execute-stage instruction writes a register |
| exe_ld | input | 1 | Execute-stage instruction is a load |
| mem_dst | input | 5 | Destination register of the memory-stage instruction |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| mem_ld | input | 1 | Memory-stage instruction is a load |
| wb_dst | input | 5 | Destination register of the write-back instruction |
| wb_wr | input | 1 | Write-back instruction writes a register |
| wb_val | input | 32 | Value being written back |
| dec_val1 | output | 32 | Register file read for dec_src1 |
| dec_val2 | output | 32 | Register file read for dec_src2 |
| opa_sel | output | 2 | Select for the first ALU operand (00 register file, 01 write back, 10 memory stage) |
| opb_sel | output | 2 | Select for the second ALU operand, same encoding |
| stall | output | 1 | Hold PC and fetch/decode, insert a bubble into execute |

## Verification
Two functions of the unit can act in the same cycle. A load in execute raises a stall for the decode instruction while the execute instruction is also being fed from memory or write back, and the write-back producer writes the register file while decode reads the same register. Random vectors over a four-register window make these overlaps frequent. Each select, the stall and both read values are compared with bench functions every cycle. A directed program chains an add into four dependents and a load into a dependent subtract. It is judged by its bubble count and by final register contents against a sequential model.

// File: rtl/hz_pkg.sv
package hz_pkg;
    parameter int unsigned HZ_XLEN = 32;
    parameter int unsigned HZ_AW   = 5;
    localparam int unsigned HZ_NREG = 1 << HZ_AW;

    typedef logic [HZ_AW-1:0]   reg_t;
    typedef logic [HZ_XLEN-1:0] word_t;

    // operand source select
    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_WB  = 2'b01,
        SEL_MEM = 2'b10
    } opsel_e;

    // what a later-stage instruction will produce
    typedef struct packed {
        reg_t dst;
        logic wr;
        logic ld;
    } prod_t;

    // true when producer p fills register src (register 0 never counts)
    function automatic logic prod_hits(prod_t p, reg_t src);
        return p.wr && (p.dst != '0) && (p.dst == src);
    endfunction
endpackage

// File: rtl/hz_regfile.sv
module hz_regfile
    import hz_pkg::*;
#(
    parameter int unsigned NRD = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  reg_t  waddr,
    input  word_t wdata,
    input  reg_t  raddr [NRD],
    output word_t rdata [NRD]
);
    word_t regs [HZ_NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < HZ_NREG; i++) regs[i] <= '0;
        end else if (we && waddr != '0) begin
            regs[waddr] <= wdata;
        end
    end

    // write-then-read: a same-cycle write is visible to the reader
    for (genvar g = 0; g < NRD; g++) begin : g_rd
        always_comb begin
            if (raddr[g] == '0)
                rdata[g] = '0;
            else if (we && waddr == raddr[g])
                rdata[g] = wdata;
            else
                rdata[g] = regs[raddr[g]];
        end
    end
endmodule

// File: rtl/hz_fwd_select.sv
module hz_fwd_select
    import hz_pkg::*;
(
    input  reg_t   src,
    input  prod_t  mem_p,
    input  prod_t  wb_p,
    output opsel_e sel
);
    always_comb begin
        if (prod_hits(mem_p, src) && !mem_p.ld)
            sel = SEL_MEM;
        else if (prod_hits(wb_p, src))
            sel = SEL_WB;
        else
            sel = SEL_RF;
    end
endmodule

// File: rtl/hz_load_interlock.sv
module hz_load_interlock
    import hz_pkg::*;
(
    input  reg_t  src1,
    input  reg_t  src2,
    input  prod_t exe_p,
    output logic  hold
);
    always_comb begin
        hold = exe_p.ld && (prod_hits(exe_p, src1) || prod_hits(exe_p, src2));
    end
endmodule

// File: rtl/hz_pipe_hazard.sv
module hz_pipe_hazard
    import hz_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [HZ_AW-1:0]     dec_src1,
    input  logic [HZ_AW-1:0]     dec_src2,
    input  logic [HZ_AW-1:0]     exe_src1,
    input  logic [HZ_AW-1:0]     exe_src2,
    input  logic [HZ_AW-1:0]     exe_dst,
    input  logic                 exe_wr,
    input  logic                 exe_ld,
    input  logic [HZ_AW-1:0]     mem_dst,
    input  logic                 mem_wr,
    input  logic                 mem_ld,
    input  logic [HZ_AW-1:0]     wb_dst,
    input  logic                 wb_wr,
    input  logic [HZ_XLEN-1:0]   wb_val,
    output logic [HZ_XLEN-1:0]   dec_val1,
    output logic [HZ_XLEN-1:0]   dec_val2,
    output logic [1:0]           opa_sel,
    output logic [1:0]           opb_sel,
    output logic                 stall
);
    localparam int unsigned NOPND = 2;

    prod_t  exe_p, mem_p, wb_p;
    reg_t   rd_addr [NOPND];
    word_t  rd_data [NOPND];
    reg_t   ex_src  [NOPND];
    opsel_e ex_sel  [NOPND];

    assign exe_p = '{dst: exe_dst, wr: exe_wr, ld: exe_ld};
    assign mem_p = '{dst: mem_dst, wr: mem_wr, ld: mem_ld};
    assign wb_p  = '{dst: wb_dst,  wr: wb_wr,  ld: 1'b0};

    assign rd_addr[0] = dec_src1;
    assign rd_addr[1] = dec_src2;
    assign ex_src[0]  = exe_src1;
    assign ex_src[1]  = exe_src2;

    hz_regfile #(.NRD(NOPND)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (wb_wr),
        .waddr (wb_dst),
        .wdata (wb_val),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    for (genvar g = 0; g < NOPND; g++) begin : g_opnd
        hz_fwd_select u_sel (
            .src   (ex_src[g]),
            .mem_p (mem_p),
            .wb_p  (wb_p),
            .sel   (ex_sel[g])
        );
    end

    hz_load_interlock u_lock (
        .src1  (dec_src1),
        .src2  (dec_src2),
        .exe_p (exe_p),
        .hold  (stall)
    );

    assign dec_val1 = rd_data[0];
    assign dec_val2 = rd_data[1];
    assign opa_sel  = ex_sel[0];
    assign opb_sel  = ex_sel[1];
endmodule

// File: rtl/hz_pipe_hazard_chk.sv
module hz_pipe_hazard_chk
    import hz_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [HZ_AW-1:0]   dec_src1,
    input logic [HZ_AW-1:0]   dec_src2,
    input logic [HZ_AW-1:0]   exe_src1,
    input logic [HZ_AW-1:0]   exe_src2,
    input logic [HZ_AW-1:0]   exe_dst,
    input logic               exe_wr,
    input logic               exe_ld,
    input logic [HZ_AW-1:0]   mem_dst,
    input logic               mem_wr,
    input logic               mem_ld,
    input logic [HZ_AW-1:0]   wb_dst,
    input logic               wb_wr,
    input logic [HZ_XLEN-1:0] wb_val,
    input logic [HZ_XLEN-1:0] dec_val1,
    input logic [HZ_XLEN-1:0] dec_val2,
    input logic [1:0]         opa_sel,
    input logic [1:0]         opb_sel,
    input logic               stall
);
    assert_mem_src_R1: assert property (@(posedge clk) disable iff (rst)
        (opa_sel == 2'b10) |-> (mem_wr && !mem_ld && mem_dst == exe_src1));

    assert_wb_src_R2: assert property (@(posedge clk) disable iff (rst)
        (opb_sel == 2'b01) |-> (wb_wr && wb_dst == exe_src2));

    assert_mem_beats_wb_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && !mem_ld && mem_dst == exe_src1 && exe_src1 != '0) |-> (opa_sel == 2'b10));

    assert_no_code3_R3: assert property (@(posedge clk) disable iff (rst)
        (opa_sel != 2'b11) && (opb_sel != 2'b11));

    assert_stall_cause_R4: assert property (@(posedge clk) disable iff (rst)
        stall |-> (exe_ld && exe_wr && exe_dst != '0));

    assert_no_stall_indep_R5: assert property (@(posedge clk) disable iff (rst)
        (exe_dst != dec_src1 && exe_dst != dec_src2) |-> !stall);

    assert_same_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        (wb_wr && wb_dst == dec_src1 && dec_src1 != '0) |-> (dec_val1 == wb_val));

    assert_zero_reg_R7: assert property (@(posedge clk) disable iff (rst)
        (dec_src2 == '0) |-> (dec_val2 == '0));

    assert_reset_clear_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !(wb_wr && wb_dst == dec_src1)) |-> (dec_val1 == '0));

    assert_persist_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wb_wr) && $past(wb_dst) == dec_src1 && dec_src1 != '0
         && !(wb_wr && wb_dst == dec_src1)) |-> (dec_val1 == $past(wb_val)));
endmodule

bind hz_pipe_hazard hz_pipe_hazard_chk chk (.*);

// File: tb/hz_pipe_hazard_test.sv
`timescale 1ns/1ps
module hz_pipe_hazard_test;
    import hz_pkg::*;

    logic clk = 1'b0;
    logic rst;
    reg_t dec_src1, dec_src2, exe_src1, exe_src2, exe_dst, mem_dst, wb_dst;
    logic exe_wr, exe_ld, mem_wr, mem_ld, wb_wr;
    word_t wb_val, dec_val1, dec_val2;
    logic [1:0] opa_sel, opb_sel;
    logic stall;

    always #2.5 clk = ~clk;

    hz_pipe_hazard uut (.*);

    int nchk = 0;
    int nbad = 0;
    bit done = 0;

    task automatic chk(string req, longint act, longint exp);
        nchk++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        nbad++;
        $display("FAIL watchdog: actual hung expected finished");
        report();
    end

    // ---- bench reference functions ----
    function automatic int exp_sel(reg_t s, reg_t md, logic mw, logic ml, reg_t wd, logic ww);
        if (s != 0 && mw && !ml && md == s) return 2;
        if (s != 0 && ww && wd == s) return 1;
        return 0;
    endfunction

    function automatic int exp_stall(reg_t s1, reg_t s2, reg_t xd, logic xw, logic xl);
        return (xl && xw && xd != 0 && (xd == s1 || xd == s2)) ? 1 : 0;
    endfunction

    task automatic idle();
        {dec_src1, dec_src2, exe_src1, exe_src2, exe_dst, mem_dst, wb_dst} = '0;
        {exe_wr, exe_ld, mem_wr, mem_ld, wb_wr} = '0;
        wb_val = '0;
    endtask

    task automatic do_reset();
        idle();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    // ---- mini pipeline model ----
    localparam logic [2:0] OP_NOP = 3'd0, OP_ADD = 3'd1, OP_SUB = 3'd2, OP_AND = 3'd3,
                           OP_OR = 3'd4, OP_XOR = 3'd5, OP_LW = 3'd6;
    typedef struct packed {
        logic [2:0] op;
        reg_t       rd, rs1, rs2;
        logic [7:0] imm;
    } ins_t;
    localparam int PLEN = 13;

    function automatic ins_t mk(logic [2:0] op, int rd, int a, int b, int imm);
        ins_t t;
        t.op = op; t.rd = reg_t'(rd); t.rs1 = reg_t'(a); t.rs2 = reg_t'(b); t.imm = 8'(imm);
        return t;
    endfunction

    function automatic ins_t prog(int pc);
        case (pc)
            0:  return mk(OP_LW,  2, 0, 0, 0);
            1:  return mk(OP_LW,  3, 0, 0, 1);
            2:  return mk(OP_NOP, 0, 0, 0, 0);
            3:  return mk(OP_ADD, 1, 2, 3, 0);
            4:  return mk(OP_SUB, 4, 1, 3, 0);
            5:  return mk(OP_AND, 5, 1, 2, 0);
            6:  return mk(OP_OR,  6, 1, 4, 0);
            7:  return mk(OP_XOR, 7, 1, 5, 0);
            8:  return mk(OP_LW,  8, 0, 0, 5);
            9:  return mk(OP_SUB, 9, 8, 1, 0);
            10: return mk(OP_ADD, 0, 1, 1, 0);
            11: return mk(OP_ADD, 10, 0, 9, 0);
            default: return mk(OP_NOP, 0, 0, 0, 0);
        endcase
    endfunction

    function automatic word_t dmem(word_t a);
        return (a + 1) * 11;
    endfunction

    function automatic word_t alu(logic [2:0] op, word_t a, word_t b, logic [7:0] imm);
        case (op)
            OP_ADD: return a + b;
            OP_SUB: return a - b;
            OP_AND: return a & b;
            OP_OR:  return a | b;
            OP_XOR: return a ^ b;
            OP_LW:  return a + word_t'(imm);
            default: return '0;
        endcase
    endfunction

    initial begin
        word_t shadow [HZ_NREG];
        word_t refr [HZ_NREG];
        ins_t fd, dx, xm, mw, nfd, ndx, nxm, nmw;
        word_t dx_a, dx_b, xm_r, mw_r, ndx_a, ndx_b, nxm_r, nmw_r, oa, ob;
        int pc, npc, stalls;
        logic pw_we;
        reg_t pw_dst;
        word_t pw_val;

        void'($urandom(32'd4242));
        do_reset();

        // R8: reset state
        #1;
        dec_src1 = 5'd5; dec_src2 = 5'd9;
        #1;
        chk("R8 read after reset", dec_val1, 0);
        chk("R8 read after reset port2", dec_val2, 0);
        chk("R8 idle opa_sel", opa_sel, 0);
        chk("R8 idle stall", stall, 0);

        // directed corners: priority, r0, load-use, independent slot
        @(posedge clk); #1;
        idle();
        exe_src1 = 5'd3; exe_src2 = 5'd3;
        mem_dst = 5'd3; mem_wr = 1; wb_dst = 5'd3; wb_wr = 1; wb_val = 0;
        #1;
        chk("R3 mem over wb", opa_sel, 2);
        mem_ld = 1;
        #1;
        chk("R2 load in mem falls to wb", opb_sel, 1);
        exe_src1 = 0; mem_dst = 0; wb_dst = 0; mem_ld = 0;
        #1;
        chk("R7 r0 no bypass", opa_sel, 0);
        exe_dst = 0; exe_wr = 1; exe_ld = 1; dec_src1 = 0;
        #1;
        chk("R7 r0 no stall", stall, 0);
        exe_dst = 5'd4; dec_src1 = 5'd6; dec_src2 = 5'd4;
        #1;
        chk("R4 load-use on src2", stall, 1);
        dec_src2 = 5'd7;
        #1;
        chk("R5 independent slot", stall, 0);
        idle();

        for (int i = 0; i < HZ_NREG; i++) shadow[i] = '0;
        pw_we = 0; pw_dst = '0; pw_val = '0;

        // random vectors over a small register window
        for (int n = 0; n < 3000; n++) begin
            @(posedge clk);
            if (pw_we && pw_dst != 0) shadow[pw_dst] = pw_val;
            #1;
            dec_src1 = reg_t'($urandom_range(3, 0));
            dec_src2 = reg_t'($urandom_range(3, 0));
            exe_src1 = reg_t'($urandom_range(3, 0));
            exe_src2 = reg_t'($urandom_range(3, 0));
            exe_dst  = reg_t'($urandom_range(3, 0));
            mem_dst  = reg_t'($urandom_range(3, 0));
            wb_dst   = reg_t'($urandom_range(3, 0));
            exe_wr = 1'($urandom); exe_ld = 1'($urandom);
            mem_wr = 1'($urandom); mem_ld = 1'($urandom);
            wb_wr  = 1'($urandom);
            wb_val = $urandom;
            pw_we = wb_wr; pw_dst = wb_dst; pw_val = wb_val;
            #1;
            chk("R1/R2/R3 opa_sel", opa_sel, exp_sel(exe_src1, mem_dst, mem_wr, mem_ld, wb_dst, wb_wr));
            chk("R1/R2/R3 opb_sel", opb_sel, exp_sel(exe_src2, mem_dst, mem_wr, mem_ld, wb_dst, wb_wr));
            chk("R4/R5 stall", stall, exp_stall(dec_src1, dec_src2, exe_dst, exe_wr, exe_ld));
            chk("R6/R7/R10 dec_val1", dec_val1,
                (dec_src1 == 0) ? 0 : (wb_wr && wb_dst == dec_src1) ? wb_val : shadow[dec_src1]);
            chk("R6/R7/R10 dec_val2", dec_val2,
                (dec_src2 == 0) ? 0 : (wb_wr && wb_dst == dec_src2) ? wb_val : shadow[dec_src2]);
        end

        // ---- R9: program through a pipeline around the unit ----
        do_reset();
        fd = '0; dx = '0; xm = '0; mw = '0;
        dx_a = 0; dx_b = 0; xm_r = 0; mw_r = 0;
        nfd = '0; ndx = '0; nxm = '0; nmw = '0;
        ndx_a = 0; ndx_b = 0; nxm_r = 0; nmw_r = 0;
        pc = 0; npc = 0; stalls = 0;
        for (int c = 0; c < PLEN + 12; c++) begin
            @(posedge clk);
            if (c > 0) begin
                fd = nfd; dx = ndx; xm = nxm; mw = nmw;
                dx_a = ndx_a; dx_b = ndx_b; xm_r = nxm_r; mw_r = nmw_r; pc = npc;
            end
            #1;
            dec_src1 = fd.rs1; dec_src2 = fd.rs2;
            exe_src1 = dx.rs1; exe_src2 = dx.rs2; exe_dst = dx.rd;
            exe_wr = (dx.op != OP_NOP); exe_ld = (dx.op == OP_LW);
            mem_dst = xm.rd; mem_wr = (xm.op != OP_NOP); mem_ld = (xm.op == OP_LW);
            wb_dst = mw.rd; wb_wr = (mw.op != OP_NOP); wb_val = mw_r;
            #1;
            oa = (opa_sel == 2) ? xm_r : (opa_sel == 1) ? mw_r : dx_a;
            ob = (opb_sel == 2) ? xm_r : (opb_sel == 1) ? mw_r : dx_b;
            nmw = xm; nmw_r = (xm.op == OP_LW) ? dmem(xm_r) : xm_r;
            nxm = dx; nxm_r = alu(dx.op, oa, ob, dx.imm);
            if (stall) begin
                stalls++;
                ndx = '0; ndx_a = 0; ndx_b = 0;
                nfd = fd; npc = pc;
            end else begin
                ndx = fd; ndx_a = dec_val1; ndx_b = dec_val2;
                nfd = prog(pc); npc = pc + 1;
            end
        end

        // sequential reference
        for (int i = 0; i < HZ_NREG; i++) refr[i] = '0;
        for (int p = 0; p < PLEN; p++) begin
            ins_t t;
            word_t r;
            t = prog(p);
            r = alu(t.op, refr[t.rs1], refr[t.rs2], t.imm);
            if (t.op == OP_LW) r = dmem(r);
            if (t.op != OP_NOP && t.rd != 0) refr[t.rd] = r;
        end

        chk("R9 one bubble per load-use", stalls, 1);
        @(posedge clk); #1;
        idle();
        for (int i = 0; i <= 10; i++) begin
            dec_src1 = reg_t'(i);
            #1;
            chk("R9 final register", dec_val1, refr[i]);
        end
        report();
    end
endmodule